// File: doc/BRIEF.md
# Asynchronous Bus Cycle Terminator

This block is the bus-master sequencer that sits between a processor core and an external bus where each transfer ends on a handshake. The core hands it a request with an address, write data and a cycle kind: read, write, or read-modify-write. The block then steps through numbered states, one state per clock of its own clock, which runs at twice the bus rate. It drives the address strobe, data strobe, read/write line and the tri-state enables. It samples the slave's acknowledge, error and halt lines through a two-flop synchroniser. Each cycle ends in one of three ways: normal completion, bus-error termination, or a rerun of the same cycle.

An error is accepted in two cases. The first is while the sequencer waits for acknowledge. The second is a short window after a synchronised acknowledge, which catches a slave that reports a fault just after it has answered. A recognised error moves the sequencer to a fixed abort state. That state is S9 for a read, a write, or the read half of a read-modify-write, and S21 for the write half. The address and data enables stay off for as long as the synchronised error stays high. When halt is also high, the block holds off until both lines clear and then starts the identical cycle again from S0. Otherwise it reports the error to the core when the error line drops.

Top module: `bcyc_term`

## Requirements
- R1: After reset, and whenever no cycle is in progress, the strobes and both tri-state enables are low, bus_rw is high (read), done is low and seq_state reads 0.
- R2: For a read (req_kind 2'b00; 2'b11 also runs as a read), bus_as is high in states S2 to S6 and bus_ds is never high without bus_as. Acknowledge is sampled in S4 and the read data is latched in S6. When acknowledge arrives early, done rises 8 clocks after the request is accepted, with rdata equal to bus_rdata and err_flag low.
- R3: While neither a synchronised acknowledge nor error is present in S4, the sequencer stays in S4. An acknowledge first driven while seq_state reads 4 gives done 10 clocks after acceptance.
- R4: For a write (req_kind 2'b01), bus_rw is low and bus_data_oe is high in states S3 to S6, with bus_wdata equal to the request's write data. Data is never driven while bus_rw is high.
- R5: A read-modify-write (req_kind 2'b10) holds bus_as high from S2 through S20. It runs its write half in S14 to S21 with bus_rw low, and returns the read-half data in rdata. With prompt acknowledges, done comes 22 clocks after acceptance.
- R6: An error that is synchronised while the sequencer waits in S4, with halt low, ends a read, a write or a read-half cycle at state S9.
- R7: An error whose synchronised value arrives within LATE_WIN clocks (default 2: states S5 and S6) after the synchronised acknowledge ends the cycle at S9. One that arrives later is ignored, and the cycle completes with err_flag low.
- R8: An error during the write half of a read-modify-write ends the cycle at S21, and rdata still holds the read-half data.
- R9: After termination, while the error input stays high, bus_addr_oe, bus_data_oe, bus_as and bus_ds are all low. Done then comes with err_flag high once the error line is low.
- R10: Error together with halt puts the block into a rerun wait. Once both are low, it restarts at S0 with the same address, data and kind. retry_flag pulses for one clock at the restart, with done low.
- R11: Halt asserted without error has no effect: the cycle completes normally with err_flag low and no retry pulse.
- R12: done is a one-clock pulse, and err_flag is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one state per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a cycle; accepted when no cycle is in progress |
| req_kind | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data (write half for read-modify-write) |
| bus_rdata | input | DW | Read data from the bus |
| bus_ack | input | 1 | Slave acknowledge, asynchronous |
| bus_err | input | 1 | Slave bus error, asynchronous |
| bus_halt | input | 1 | Halt request, asynchronous |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_addr | output | AW | Address value, valid when bus_addr_oe is high |
| bus_wdata | output | DW | Write data value, valid when bus_data_oe is high |
| bus_addr_oe | output | 1 | Address and control drive enable |
| bus_data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | DW | Latched read data |
| err_flag | output | 1 | Cycle ended in a bus error (with done) |
| retry_flag | output | 1 | One-clock pulse at the restart of a rerun cycle |
| seq_state | output | 5 | Current state number, 0 when no cycle is in progress |

## Verification
The hardest cases to reach are the ones where timing sits right at the edge of the late-error window. An error has to land exactly one clock after acknowledge to be recognised, or exactly one clock later still to be ignored, and both inputs pass through the two-flop synchroniser first. The bench acts as the slave and watches seq_state at falling edges. It raises the error line when a chosen state number appears, so that the synchronised value reaches the sequencer in S6 (recognised) or in S7 (ignored). The write-half abort at S21 is reached the same way: the bench withholds the write-half acknowledge and raises the error in S16.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_TERM  = 2'd2,
        MODE_RERUN = 2'd3
    } bcyc_mode_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_RMW   = 2'b10,
        KIND_RSVD  = 2'b11
    } bcyc_kind_e;

    localparam int unsigned ST_W = 5;

    // state numbers the sequencing depends on
    localparam logic [ST_W-1:0] ST_AS_ON     = 5'd2;
    localparam logic [ST_W-1:0] ST_DOE_ON    = 5'd3;
    localparam logic [ST_W-1:0] ST_SAMPLE    = 5'd4;
    localparam logic [ST_W-1:0] ST_LATCH     = 5'd6;
    localparam logic [ST_W-1:0] ST_LAST      = 5'd7;
    localparam logic [ST_W-1:0] ST_MOD_FIRST = 5'd8;
    localparam logic [ST_W-1:0] ST_MOD_LAST  = 5'd13;
    localparam logic [ST_W-1:0] ST_WR_BASE   = 5'd14;
    localparam logic [ST_W-1:0] ST_RMW_AS_HI = 5'd20;
    localparam logic [ST_W-1:0] ST_RD_ABORT  = 5'd9;
    localparam logic [ST_W-1:0] ST_WR_ABORT  = 5'd21;

    // true in the write half of a read-modify-write
    function automatic logic in_write_half(input logic [ST_W-1:0] st);
        return st >= ST_WR_BASE;
    endfunction

    // internal modify gap between the two halves
    function automatic logic in_modify_gap(input logic [ST_W-1:0] st);
        return (st >= ST_MOD_FIRST) && (st <= ST_MOD_LAST);
    endfunction

    // position inside the current half, so both halves share one timing
    function automatic logic [ST_W-1:0] half_step(input logic [ST_W-1:0] st);
        return in_write_half(st) ? (st - ST_WR_BASE) : st;
    endfunction

endpackage

// File: rtl/bcyc_sync.sv
module bcyc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/bcyc_late_win.sv
module bcyc_late_win #(
    parameter int unsigned LATE_WIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clear_i,
    output logic open_o
);

    localparam int unsigned CW = $clog2(LATE_WIN + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)          cnt_d = '0;
        else if (arm_i)       cnt_d = CW'(LATE_WIN);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign open_o = (cnt_q != '0);

endmodule

// File: rtl/bcyc_strobe.sv
module bcyc_strobe
    import bcyc_pkg::*;
(
    input  bcyc_mode_e      mode_i,
    input  logic [ST_W-1:0] st_i,
    input  bcyc_kind_e      kind_i,
    output logic            as_o,
    output logic            ds_o,
    output logic            rw_o,
    output logic            addr_oe_o,
    output logic            data_oe_o
);

    logic            run;
    logic            writing;
    logic [ST_W-1:0] step;

    always_comb begin
        run     = (mode_i == MODE_RUN);
        step    = half_step(st_i);
        writing = (kind_i == KIND_WRITE) ||
                  ((kind_i == KIND_RMW) && in_write_half(st_i));

        if (kind_i == KIND_RMW)
            as_o = run && (st_i >= ST_AS_ON) && (st_i <= ST_RMW_AS_HI);
        else
            as_o = run && (st_i >= ST_AS_ON) && (st_i < ST_LAST);

        if (writing)
            ds_o = run && (step >= ST_SAMPLE) && (step < ST_LAST);
        else
            ds_o = run && !in_modify_gap(st_i) &&
                   (step >= ST_AS_ON) && (step < ST_LAST);

        data_oe_o = run && writing && (step >= ST_DOE_ON) && (step < ST_LAST);
        rw_o      = !(run && writing);
        addr_oe_o = run;
    end

endmodule

// File: rtl/bcyc_seq.sv
module bcyc_seq
    import bcyc_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [1:0]      req_kind_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic [DW-1:0]   req_wdata_i,
    input  logic [DW-1:0]   bus_rdata_i,
    input  logic            s_ack_i,
    input  logic            s_err_i,
    input  logic            s_halt_i,
    input  logic            win_open_i,
    output logic            win_arm_o,
    output logic            win_clear_o,
    output bcyc_mode_e      mode_o,
    output logic [ST_W-1:0] st_o,
    output bcyc_kind_e      kind_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o,
    output logic [DW-1:0]   rdata_o,
    output logic            done_o,
    output logic            err_o,
    output logic            retry_o
);

    typedef struct packed {
        bcyc_mode_e      mode;
        logic [ST_W-1:0] st;
        bcyc_kind_e      kind;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic            done;
        logic            err;
        logic            retry;
    } seq_t;

    seq_t cur_q;
    seq_t nxt_d;

    logic            wr_half;
    logic [ST_W-1:0] step;
    logic            read_half;
    logic            abort;
    logic            finish;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.done  = 1'b0;
        nxt_d.err   = 1'b0;
        nxt_d.retry = 1'b0;
        win_arm_o   = 1'b0;
        win_clear_o = 1'b0;
        abort       = 1'b0;
        finish      = 1'b0;

        wr_half   = in_write_half(cur_q.st);
        step      = half_step(cur_q.st);
        read_half = !wr_half && (cur_q.kind != KIND_WRITE);

        unique case (cur_q.mode)
            MODE_IDLE: begin
                if (req_valid_i) begin
                    nxt_d.mode  = MODE_RUN;
                    nxt_d.st    = '0;
                    nxt_d.kind  = (bcyc_kind_e'(req_kind_i) == KIND_RSVD) ?
                                  KIND_READ : bcyc_kind_e'(req_kind_i);
                    nxt_d.addr  = req_addr_i;
                    nxt_d.wdata = req_wdata_i;
                end
            end

            MODE_RUN: begin
                if (in_modify_gap(cur_q.st)) begin
                    nxt_d.st = cur_q.st + 5'd1;
                end else if (step == ST_SAMPLE) begin
                    if (s_err_i) begin
                        abort = 1'b1;
                    end else if (s_ack_i) begin
                        nxt_d.st  = cur_q.st + 5'd1;
                        win_arm_o = 1'b1;
                    end
                end else if (win_open_i && s_err_i) begin
                    abort = 1'b1;
                end else begin
                    if ((step == ST_LATCH) && read_half)
                        nxt_d.rdata = bus_rdata_i;
                    if ((step == ST_LAST) && ((cur_q.kind != KIND_RMW) || wr_half))
                        finish = 1'b1;
                    else
                        nxt_d.st = cur_q.st + 5'd1;
                end

                if (abort) begin
                    nxt_d.mode  = s_halt_i ? MODE_RERUN : MODE_TERM;
                    nxt_d.st    = wr_half ? ST_WR_ABORT : ST_RD_ABORT;
                    win_clear_o = 1'b1;
                end else if (finish) begin
                    nxt_d.mode = MODE_IDLE;
                    nxt_d.done = 1'b1;
                end
            end

            MODE_TERM: begin
                if (!s_err_i) begin
                    nxt_d.mode = MODE_IDLE;
                    nxt_d.done = 1'b1;
                    nxt_d.err  = 1'b1;
                end
            end

            MODE_RERUN: begin
                if (!s_err_i && !s_halt_i) begin
                    nxt_d.mode  = MODE_RUN;
                    nxt_d.st    = '0;
                    nxt_d.retry = 1'b1;
                end
            end

            default: nxt_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.mode <= MODE_IDLE;
            cur_q.kind <= KIND_READ;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mode_o  = cur_q.mode;
    assign st_o    = cur_q.st;
    assign kind_o  = cur_q.kind;
    assign addr_o  = cur_q.addr;
    assign wdata_o = cur_q.wdata;
    assign rdata_o = cur_q.rdata;
    assign done_o  = cur_q.done;
    assign err_o   = cur_q.err;
    assign retry_o = cur_q.retry;

endmodule

// File: rtl/bcyc_term.sv
module bcyc_term
    import bcyc_pkg::*;
#(
    parameter int unsigned AW          = 24,
    parameter int unsigned DW          = 16,
    parameter int unsigned LATE_WIN    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic          bus_halt,
    output logic          bus_as,
    output logic          bus_ds,
    output logic          bus_rw,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_addr_oe,
    output logic          bus_data_oe,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          err_flag,
    output logic          retry_flag,
    output logic [4:0]    seq_state
);

    localparam int unsigned N_SYNC = 3;

    logic [N_SYNC-1:0] sync_vec;
    logic              sync_ack;
    logic              sync_err;
    logic              sync_halt;
    logic              win_arm;
    logic              win_clear;
    logic              win_open;
    bcyc_mode_e        mode;
    logic [ST_W-1:0]   st;
    bcyc_kind_e        kind;

    bcyc_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_halt, bus_err, bus_ack}),
        .sync_o  (sync_vec)
    );

    assign sync_ack  = sync_vec[0];
    assign sync_err  = sync_vec[1];
    assign sync_halt = sync_vec[2];

    bcyc_late_win #(
        .LATE_WIN (LATE_WIN)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (win_arm),
        .clear_i (win_clear),
        .open_o  (win_open)
    );

    bcyc_seq #(
        .AW (AW),
        .DW (DW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_kind_i  (req_kind),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .bus_rdata_i (bus_rdata),
        .s_ack_i     (sync_ack),
        .s_err_i     (sync_err),
        .s_halt_i    (sync_halt),
        .win_open_i  (win_open),
        .win_arm_o   (win_arm),
        .win_clear_o (win_clear),
        .mode_o      (mode),
        .st_o        (st),
        .kind_o      (kind),
        .addr_o      (bus_addr),
        .wdata_o     (bus_wdata),
        .rdata_o     (rdata),
        .done_o      (done),
        .err_o       (err_flag),
        .retry_o     (retry_flag)
    );

    bcyc_strobe u_strobe (
        .mode_i    (mode),
        .st_i      (st),
        .kind_i    (kind),
        .as_o      (bus_as),
        .ds_o      (bus_ds),
        .rw_o      (bus_rw),
        .addr_oe_o (bus_addr_oe),
        .data_oe_o (bus_data_oe)
    );

    assign seq_state = (mode == MODE_IDLE) ? 5'd0 : st;

endmodule

// File: rtl/bcyc_term_chk.sv
module bcyc_term_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       err_flag,
    input logic       retry_flag,
    input logic [4:0] seq_state,
    input logic       bus_as,
    input logic       bus_ds,
    input logic       bus_rw,
    input logic       bus_addr_oe,
    input logic       bus_data_oe,
    input logic       sy_err
);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> done);

    assert_ds_inside_as_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds |-> bus_as);

    assert_as_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as) |-> (seq_state == 5'd2));

    assert_data_only_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !bus_rw);

    // abort states with the error still high: nothing is driven
    assert_hiz_while_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sy_err && bus_rw && !bus_as && ((seq_state == 5'd9) || (seq_state == 5'd21)))
        |-> (!bus_addr_oe && !bus_data_oe && !bus_ds));

    assert_retry_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        retry_flag |-> ((seq_state == 5'd0) && !done && bus_addr_oe));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr_oe |-> (!bus_as && !bus_ds && !bus_data_oe));

endmodule

bind bcyc_term bcyc_term_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .err_flag    (err_flag),
    .retry_flag  (retry_flag),
    .seq_state   (seq_state),
    .bus_as      (bus_as),
    .bus_ds      (bus_ds),
    .bus_rw      (bus_rw),
    .bus_addr_oe (bus_addr_oe),
    .bus_data_oe (bus_data_oe),
    .sy_err      (sync_err)
);

// File: tb/test_bcyc_term.sv
`timescale 1ns/1ps
module test_bcyc_term;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [23:0] req_addr;
    logic [15:0] req_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic        bus_err;
    logic        bus_halt;
    logic        bus_as, bus_ds, bus_rw, bus_addr_oe, bus_data_oe;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        done, err_flag, retry_flag;
    logic [15:0] rdata;
    logic [4:0]  seq_state;

    int vectors = 0;
    int miscompares = 0;

    // slave model controls
    bit         ack_en = 1'b1;
    bit         wr_ack_en = 1'b1;
    logic [4:0] ack_min = 5'd2;

    always #2 clk = ~clk;

    bcyc_term i_bcyc_term (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_halt(bus_halt),
        .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_addr_oe(bus_addr_oe), .bus_data_oe(bus_data_oe),
        .done(done), .rdata(rdata), .err_flag(err_flag), .retry_flag(retry_flag),
        .seq_state(seq_state)
    );

    // slave acknowledges while the strobe is up in the chosen states
    always @(negedge clk) begin
        if (!rst_n) bus_ack <= 1'b0;
        else bus_ack <= bus_as && (
            (ack_en && seq_state >= ack_min && seq_state <= 5'd6) ||
            (ack_en && wr_ack_en && seq_state >= 5'd16 && seq_state <= 5'd20));
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_req(input logic [1:0] k, input logic [23:0] a, input logic [15:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag, output int cnt, output logic e,
                             output logic [15:0] rd, output bit saw_retry);
        bit hit = 0;
        cnt = 0; saw_retry = 0; e = 1'b0; rd = '0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (retry_flag) saw_retry = 1;
            if (done) begin hit = 1; e = err_flag; rd = rdata; break; end
        end
        if (!hit) chk({tag, " done timeout"}, 32'd0, 32'd1);
    endtask

    task automatic wait_state(input logic [4:0] s, output bit hit);
        hit = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (seq_state == s) begin hit = 1; break; end
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 done after reset", done, 0);
        chk("R1 as after reset", bus_as, 0);
        chk("R1 addr_oe after reset", bus_addr_oe, 0);
        chk("R1 data_oe after reset", bus_data_oe, 0);
        chk("R1 rw after reset", bus_rw, 1);
        chk("R1 state after reset", seq_state, 0);
    endtask

    task automatic t_read();
        int c; logic e; logic [15:0] rd; bit r;
        bus_rdata = 16'hA5C3; ack_min = 5'd2;
        start_req(2'b00, 24'h12_3456, 16'h0);
        wait_done("R2", c, e, rd, r);
        chk("R2 read clocks", c, 8);
        chk("R2 read data", rd, 16'hA5C3);
        chk("R2 read err", e, 0);
        @(negedge clk);
        chk("R12 done single pulse", done, 0);
        chk("R12 err without done", err_flag, 0);
        chk("R1 idle state after read", seq_state, 0);
        settle();
        bus_rdata = 16'h0F0F;
        start_req(2'b11, 24'h00_0002, 16'h0);
        wait_done("R2 kind11", c, e, rd, r);
        chk("R2 kind 11 runs as read", rd, 16'h0F0F);
        settle();
    endtask

    task automatic t_wait();
        int c; logic e; logic [15:0] rd; bit r;
        bus_rdata = 16'h7E01; ack_min = 5'd4;
        start_req(2'b00, 24'h00_0100, 16'h0);
        wait_done("R3", c, e, rd, r);
        chk("R3 wait-state clocks", c, 10);
        chk("R3 wait-state data", rd, 16'h7E01);
        ack_min = 5'd2;
        settle();
    endtask

    task automatic t_write();
        int c; logic e; logic [15:0] rd; bit r; bit h;
        start_req(2'b01, 24'h00_0ABC, 16'hBEEF);
        wait_state(5'd5, h);
        chk("R4 write reaches S5", h, 1);
        chk("R4 write rw low", bus_rw, 0);
        chk("R4 write data_oe", bus_data_oe, 1);
        chk("R4 write data value", bus_wdata, 16'hBEEF);
        wait_done("R4", c, e, rd, r);
        chk("R4 write err", e, 0);
        settle();
    endtask

    task automatic t_rmw();
        int c; logic e; logic [15:0] rd; bit r; bit h;
        bus_rdata = 16'h1357;
        start_req(2'b10, 24'h00_4000, 16'h2468);
        wait_done("R5 count", c, e, rd, r);
        chk("R5 rmw clocks", c, 22);
        chk("R5 rmw read data", rd, 16'h1357);
        chk("R5 rmw err", e, 0);
        settle();
        start_req(2'b10, 24'h00_4002, 16'h9999);
        wait_state(5'd10, h);
        chk("R5 as held in modify gap", bus_as, 1);
        chk("R5 rw high in modify gap", bus_rw, 1);
        bus_rdata = 16'hDEAD;
        wait_state(5'd17, h);
        chk("R5 write half rw", bus_rw, 0);
        chk("R5 write half data_oe", bus_data_oe, 1);
        chk("R5 write half data", bus_wdata, 16'h9999);
        wait_done("R5", c, e, rd, r);
        chk("R5 rdata kept from read half", rd, 16'h1357);
        settle();
    endtask

    task automatic t_err_normal();
        int c; logic e; logic [15:0] rd; bit r; bit h;
        ack_en = 1'b0;
        start_req(2'b00, 24'h00_0200, 16'h0);
        wait_state(5'd2, h);
        bus_err = 1'b1;
        wait_state(5'd9, h);
        chk("R6 abort at S9", h, 1);
        chk("R9 addr_oe off", bus_addr_oe, 0);
        chk("R9 as off", bus_as, 0);
        repeat (3) @(negedge clk);
        chk("R9 still off while err held", bus_addr_oe, 0);
        chk("R9 data_oe off", bus_data_oe, 0);
        chk("R9 no done while err held", done, 0);
        bus_err = 1'b0;
        wait_done("R9", c, e, rd, r);
        chk("R9 err_flag with done", e, 1);
        chk("R10 no retry on plain error", r, 0);
        ack_en = 1'b1;
        settle();
    endtask

    task automatic t_err_late();
        int c; logic e; logic [15:0] rd; bit r; bit h;
        start_req(2'b00, 24'h00_0300, 16'h0);
        wait_state(5'd4, h);
        bus_err = 1'b1;
        wait_state(5'd9, h);
        chk("R7 late error aborts at S9", h, 1);
        bus_err = 1'b0;
        wait_done("R7 late", c, e, rd, r);
        chk("R7 late error flag", e, 1);
        settle();
        bus_rdata = 16'h4242;
        start_req(2'b00, 24'h00_0304, 16'h0);
        wait_state(5'd5, h);
        bus_err = 1'b1;
        wait_done("R7 too late", c, e, rd, r);
        chk("R7 error after window ignored", e, 0);
        chk("R7 data after ignored error", rd, 16'h4242);
        bus_err = 1'b0;
        settle();
    endtask

    task automatic t_rmw_wr_err();
        int c; logic e; logic [15:0] rd; bit r; bit h;
        bus_rdata = 16'hC0DE; wr_ack_en = 1'b0;
        start_req(2'b10, 24'h00_5000, 16'h1111);
        wait_state(5'd16, h);
        bus_err = 1'b1;
        wait_state(5'd21, h);
        chk("R8 write half abort at S21", h, 1);
        chk("R8 rw released", bus_rw, 1);
        chk("R9 data_oe off in write abort", bus_data_oe, 0);
        bus_err = 1'b0;
        wait_done("R8", c, e, rd, r);
        chk("R8 err flag", e, 1);
        chk("R8 read half data kept", rd, 16'hC0DE);
        wr_ack_en = 1'b1;
        settle();
        ack_en = 1'b0;
        start_req(2'b10, 24'h00_5002, 16'h1111);
        wait_state(5'd2, h);
        bus_err = 1'b1;
        wait_state(5'd9, h);
        chk("R6 read half abort at S9", h, 1);
        bus_err = 1'b0;
        wait_done("R6 rmw", c, e, rd, r);
        chk("R6 rmw read half err flag", e, 1);
        ack_en = 1'b1;
        settle();
    endtask

    task automatic t_retry();
        int c; logic e; logic [15:0] rd; bit r; bit h;
        ack_en = 1'b0; bus_rdata = 16'h5A5A;
        start_req(2'b00, 24'h00_6006, 16'h0);
        wait_state(5'd2, h);
        bus_err = 1'b1; bus_halt = 1'b1;
        wait_state(5'd9, h);
        chk("R10 rerun wait entered", h, 1);
        repeat (3) @(negedge clk);
        chk("R10 bus released in rerun wait", bus_addr_oe, 0);
        chk("R10 no done in rerun wait", done, 0);
        bus_err = 1'b0; bus_halt = 1'b0; ack_en = 1'b1;
        h = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (retry_flag) begin h = 1; break; end
        end
        chk("R10 retry pulse", h, 1);
        chk("R10 restart at S0", seq_state, 0);
        chk("R10 same address", bus_addr, 24'h00_6006);
        chk("R10 done low at restart", done, 0);
        wait_done("R10", c, e, rd, r);
        chk("R10 rerun completes clean", e, 0);
        chk("R10 rerun data", rd, 16'h5A5A);
        settle();
    endtask

    task automatic t_halt_only();
        int c; logic e; logic [15:0] rd; bit r;
        bus_halt = 1'b1; bus_rdata = 16'h3C3C;
        start_req(2'b00, 24'h00_7000, 16'h0);
        wait_done("R11", c, e, rd, r);
        chk("R11 halt alone clocks", c, 8);
        chk("R11 halt alone err", e, 0);
        chk("R11 halt alone retry", r, 0);
        chk("R11 halt alone data", rd, 16'h3C3C);
        bus_halt = 1'b0;
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
        req_wdata = '0; bus_rdata = '0; bus_err = 1'b0; bus_halt = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_wait();
        t_write();
        t_rmw();
        t_err_normal();
        t_err_late();
        t_rmw_wr_err();
        t_retry();
        t_halt_only();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule